// File: doc/BRIEF.md
# Outlet Cell Filter and Knockout Concentrator

This block sits in front of one output port of an N-input, N-output switch that moves fixed-length cells. In every cell time all N inputs present a slot at once. Each slot has a valid bit, a destination outlet address and a payload tag. One address filter per input keeps only the cells that are addressed to this outlet. The surviving cells then enter a cascade of knockout sections. Each section is a tree of 2-input contention elements. If one side of an element holds a cell, that cell wins. If both sides hold a cell, the lower-numbered input wins and the other cell is passed on to the next section. Section j therefore picks the j-th surviving cell in input order and puts it on output lane j.

Only L lanes exist. Any cells left over after the last section are discarded. The number discarded in each cell time is reported on a pulse output. A running count of discarded cells is also kept. A small state machine keeps this count from wrapping: in state TALLY it adds each cycle's drops, it takes the transition TALLY to PINNED when the sum reaches the counter's ceiling, and it stays in PINNED until reset. All outputs are registered, so results appear one clock after the inputs are sampled. The defaults are 16 inputs, 12 lanes, 8-bit tags and a 32-bit loss counter.

Top module: `ko_concentrator`

## Requirements
- R1: A cell on input i takes part in concentration only when `cell_vld[i]` is 1 and its destination field `cell_dest[i*ADDR_W +: ADDR_W]` equals `outlet_addr`.
- R2: Output lane j (tag field `lane_tag[j*TAG_W +: TAG_W]`) carries the tag of the j-th matching cell, counted in ascending input index from j = 0. When two cells contend, the lower input index wins.
- R3: The valid lanes always form a contiguous prefix starting at lane 0. Their number equals min(k, N_LANE), where k is the number of matching cells. The tag field of an invalid lane reads 0.
- R4: `drop_now` equals k − N_LANE when k > N_LANE, and 0 otherwise.
- R5: Every lane output and `drop_now` reflects the inputs sampled at the previous rising clock edge (one cycle of latency).
- R6: `drop_total` increases each cycle by the value `drop_now` takes in that same cycle. It saturates at all ones of its CNT_W bits, which is 32 bits by default.
- R7: While `rst_n` is low, all lanes are invalid, tags, `drop_now` and `drop_total` are 0, and the counter state returns to TALLY.
- R8: A cell whose valid bit is 0 has no effect on any output, even when its destination equals `outlet_addr`.
- R9: Once the counter reaches its ceiling it enters PINNED. It then holds that value for any further drops until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cell time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| outlet_addr | input | ADDR_W | Static address of this outlet |
| cell_vld | input | N_IN | Per-input valid bits |
| cell_dest | input | N_IN*ADDR_W | Per-input destination addresses, input i at bits i*ADDR_W |
| cell_tag | input | N_IN*TAG_W | Per-input payload tags, input i at bits i*TAG_W |
| lane_vld | output | N_LANE | Per-lane valid bits |
| lane_tag | output | N_LANE*TAG_W | Per-lane tags, lane j at bits j*TAG_W |
| drop_now | output | $clog2(N_IN+1) | Cells dropped in the last cell time |
| drop_total | output | CNT_W | Saturating total of dropped cells |

## Verification
The lane outputs with their drop pulse, and the counter clamp, can act in the same cycle. This happens when a heavy arrival pattern pushes the sum past the ceiling. A reduced configuration (8 inputs, 3 lanes, 6-bit counter) is swept over all 256 valid masks with every cell addressed to the outlet. This drives the count through its ceiling partway through the sweep. On the crossing cycle the bench expects the full `drop_now` value next to a `drop_total` pinned at 63. A second sweep runs after reset with mixed destinations and a different outlet address, and it re-checks the ordering of the lanes.

// File: rtl/ko_pkg.sv
package ko_pkg;
    typedef enum logic {
        TALLY  = 1'b0,
        PINNED = 1'b1
    } loss_state_e;
endpackage

// File: rtl/ko_cell_filter.sv
module ko_cell_filter #(
    parameter int ADDR_W = 4
) (
    input  logic              vld,
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] here,
    output logic              pass
);
    // R1, R8: only a valid cell addressed to this outlet goes on
    always_comb begin
        pass = vld && (dest == here);
    end
endmodule

// File: rtl/ko_duel.sv
module ko_duel #(
    parameter int TAG_W = 8,
    parameter int IDX_W = 4
) (
    input  logic             a_v,
    input  logic [TAG_W-1:0] a_tag,
    input  logic [IDX_W-1:0] a_idx,
    input  logic             b_v,
    input  logic [TAG_W-1:0] b_tag,
    input  logic [IDX_W-1:0] b_idx,
    output logic             w_v,
    output logic [TAG_W-1:0] w_tag,
    output logic [IDX_W-1:0] w_idx
);
    // Side a always carries lower input indices: it wins a contest (R2).
    always_comb begin
        w_v   = a_v | b_v;
        w_tag = a_v ? a_tag : b_tag;
        w_idx = a_v ? a_idx : b_idx;
    end
endmodule

// File: rtl/ko_section.sv
module ko_section #(
    parameter int N_IN  = 16,
    parameter int TAG_W = 8
) (
    input  logic [N_IN-1:0]       cand_v,
    input  logic [N_IN*TAG_W-1:0] cand_tag,
    output logic                  win_v,
    output logic [TAG_W-1:0]      win_tag,
    output logic [N_IN-1:0]       left_v
);
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int LEAVES = 1 << IDX_W;

    logic             nv [1:2*LEAVES-1];
    logic [TAG_W-1:0] nt [1:2*LEAVES-1];
    logic [IDX_W-1:0] ni [1:2*LEAVES-1];

    genvar g;
    generate
        for (g = 0; g < LEAVES; g++) begin : g_leaf
            if (g < N_IN) begin : g_real
                assign nv[LEAVES+g] = cand_v[g];
                assign nt[LEAVES+g] = cand_tag[g*TAG_W +: TAG_W];
                assign ni[LEAVES+g] = IDX_W'(g);
            end else begin : g_pad
                assign nv[LEAVES+g] = 1'b0;
                assign nt[LEAVES+g] = '0;
                assign ni[LEAVES+g] = '0;
            end
        end
        for (g = 1; g < LEAVES; g++) begin : g_node
            ko_duel #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_duel (
                .a_v  (nv[2*g]),
                .a_tag(nt[2*g]),
                .a_idx(ni[2*g]),
                .b_v  (nv[2*g+1]),
                .b_tag(nt[2*g+1]),
                .b_idx(ni[2*g+1]),
                .w_v  (nv[g]),
                .w_tag(nt[g]),
                .w_idx(ni[g])
            );
        end
        // Losers move on: everything except the section winner
        for (g = 0; g < N_IN; g++) begin : g_left
            assign left_v[g] = cand_v[g] & ~(nv[1] && (ni[1] == IDX_W'(g)));
        end
    endgenerate

    assign win_v   = nv[1];
    assign win_tag = nt[1];
endmodule

// File: rtl/ko_loss_counter.sv
module ko_loss_counter
    import ko_pkg::*;
#(
    parameter int ADD_W = 5,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADD_W-1:0] add,
    output logic [CNT_W-1:0] total
);
    localparam logic [CNT_W-1:0] CEIL = '1;

    loss_state_e    state_q, state_d;
    logic [CNT_W-1:0] total_q, total_d;
    logic [CNT_W:0]   sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TALLY;
            total_q <= '0;
        end else begin
            state_q <= state_d;
            total_q <= total_d;
        end
    end

    always_comb begin
        sum     = (CNT_W+1)'(total_q) + (CNT_W+1)'(add);
        state_d = state_q;
        total_d = total_q;
        unique case (state_q)
            TALLY: begin
                if (sum >= (CNT_W+1)'(CEIL)) begin
                    total_d = CEIL;
                    state_d = PINNED;
                end else begin
                    total_d = sum[CNT_W-1:0];
                end
            end
            PINNED: begin
                total_d = CEIL;
            end
            default: begin
                state_d = TALLY;
            end
        endcase
    end

    assign total = total_q;

    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PINNED) |=> (state_q == PINNED && total_q == CEIL));
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (total_q == CEIL) |=> (total_q == CEIL));
endmodule

// File: rtl/ko_concentrator.sv
module ko_concentrator #(
    parameter int N_IN   = 16,
    parameter int N_LANE = 12,
    parameter int TAG_W  = 8,
    parameter int CNT_W  = 32,
    localparam int ADDR_W = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int DROP_W = $clog2(N_IN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       outlet_addr,
    input  logic [N_IN-1:0]         cell_vld,
    input  logic [N_IN*ADDR_W-1:0]  cell_dest,
    input  logic [N_IN*TAG_W-1:0]   cell_tag,
    output logic [N_LANE-1:0]       lane_vld,
    output logic [N_LANE*TAG_W-1:0] lane_tag,
    output logic [DROP_W-1:0]       drop_now,
    output logic [CNT_W-1:0]        drop_total
);
    logic [N_IN-1:0]         match;
    logic [N_IN-1:0]         rem [0:N_LANE];
    logic [N_LANE-1:0]       win_v;
    logic [N_LANE*TAG_W-1:0] win_tag;
    logic [N_LANE*TAG_W-1:0] tag_d;
    logic [DROP_W-1:0]       drop_d;
    logic [DROP_W-1:0]       match_cnt;

    logic [N_LANE-1:0]       lane_vld_q;
    logic [N_LANE*TAG_W-1:0] lane_tag_q;
    logic [DROP_W-1:0]       drop_q;
    logic                    primed_q;

    genvar i;
    generate
        for (i = 0; i < N_IN; i++) begin : g_filt
            ko_cell_filter #(.ADDR_W(ADDR_W)) u_filt (
                .vld (cell_vld[i]),
                .dest(cell_dest[i*ADDR_W +: ADDR_W]),
                .here(outlet_addr),
                .pass(match[i])
            );
        end
        assign rem[0] = match;
        for (i = 0; i < N_LANE; i++) begin : g_sect
            ko_section #(.N_IN(N_IN), .TAG_W(TAG_W)) u_sect (
                .cand_v  (rem[i]),
                .cand_tag(cell_tag),
                .win_v   (win_v[i]),
                .win_tag (win_tag[i*TAG_W +: TAG_W]),
                .left_v  (rem[i+1])
            );
            assign tag_d[i*TAG_W +: TAG_W] = win_v[i] ? win_tag[i*TAG_W +: TAG_W] : '0;
        end
    endgenerate

    // Cells surviving every section are the ones knocked out
    always_comb begin
        drop_d    = '0;
        match_cnt = '0;
        for (int k = 0; k < N_IN; k++) begin
            drop_d    = drop_d + DROP_W'(rem[N_LANE][k]);
            match_cnt = match_cnt + DROP_W'(match[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_vld_q <= '0;
            lane_tag_q <= '0;
            drop_q     <= '0;
            primed_q   <= 1'b0;
        end else begin
            lane_vld_q <= win_v;
            lane_tag_q <= tag_d;
            drop_q     <= drop_d;
            primed_q   <= 1'b1;
        end
    end

    ko_loss_counter #(.ADD_W(DROP_W), .CNT_W(CNT_W)) u_loss (
        .clk  (clk),
        .rst_n(rst_n),
        .add  (drop_d),
        .total(drop_total)
    );

    assign lane_vld = lane_vld_q;
    assign lane_tag = lane_tag_q;
    assign drop_now = drop_q;

    assert_lane_prefix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (((lane_vld_q + 1'b1) & lane_vld_q) == '0));
    assert_drop_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_q != '0) |-> (&lane_vld_q));
    assert_conserve_R5: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> ($countones(lane_vld_q) + int'(drop_q) == int'($past(match_cnt))));
    assert_total_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (drop_total >= $past(drop_total)));
endmodule

// File: tb/test_ko_concentrator.sv
`timescale 1ns/1ps
module test_ko_concentrator;
    localparam int N = 8, L = 3, TW = 8, CW = 6, AW = 3, DW = 4;
    localparam int CEIL = 63;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   outlet_addr = '0;
    logic [N-1:0]    cell_vld = '0;
    logic [N*AW-1:0] cell_dest = '0;
    logic [N*TW-1:0] cell_tag = '0;
    logic [L-1:0]    lane_vld;
    logic [L*TW-1:0] lane_tag;
    logic [DW-1:0]   drop_now;
    logic [CW-1:0]   drop_total;

    int checks = 0, fails = 0, cycles = 0, exp_total = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ko_concentrator #(.N_IN(N), .N_LANE(L), .TAG_W(TW), .CNT_W(CW)) i_ko_concentrator (
        .clk(clk), .rst_n(rst_n), .outlet_addr(outlet_addr), .cell_vld(cell_vld),
        .cell_dest(cell_dest), .cell_tag(cell_tag), .lane_vld(lane_vld),
        .lane_tag(lane_tag), .drop_now(drop_now), .drop_total(drop_total));

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cell time, wait one edge, then compare against the reference model
    task automatic step(input logic [N-1:0] v, input logic [N*AW-1:0] d, input logic [N*TW-1:0] t);
        logic [L-1:0] ev;
        logic [L*TW-1:0] et;
        int k, dr;
        cell_vld = v; cell_dest = d; cell_tag = t;
        ev = '0; et = '0; k = 0;
        for (int i = 0; i < N; i++) begin
            if (v[i] && d[i*AW +: AW] == outlet_addr) begin   // R1, R8
                if (k < L) begin
                    ev[k] = 1'b1;
                    et[k*TW +: TW] = t[i*TW +: TW];           // R2
                end
                k++;
            end
        end
        dr = (k > L) ? k - L : 0;
        exp_total = (exp_total + dr > CEIL) ? CEIL : exp_total + dr;
        @(posedge clk);
        @(negedge clk);
        check("R3 lane valid", lane_vld, ev);
        check("R2 lane tags", lane_tag, et);
        check("R4 drop pulse (R5 latency)", drop_now, dr);
        check("R6/R9 drop total", drop_total, exp_total);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cell_vld = '1;
        @(posedge clk);
        @(negedge clk);
        check("R7 reset lanes", lane_vld, 0);
        check("R7 reset tags", lane_tag, 0);
        check("R7 reset drop", drop_now, 0);
        check("R7 reset total", drop_total, 0);
        cell_vld = '0;
        exp_total = 0;
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [N*AW-1:0] d;
        logic [N*TW-1:0] t;
        outlet_addr = 3'd5;
        do_reset();
        // Sweep 1: every valid mask, all cells for this outlet; total crosses CEIL
        for (int m = 0; m < 256; m++) begin
            for (int i = 0; i < N; i++) begin
                d[i*AW +: AW] = 3'd5;
                t[i*TW +: TW] = TW'(m * 3 + i * 29 + 1);
            end
            step(m[N-1:0], d, t);
        end
        // R9: held at ceiling by further drops
        step('1, d, t);
        check("R9 pinned", drop_total, CEIL);
        // Sweep 2 after reset: mixed destinations, other outlet address
        do_reset();
        outlet_addr = 3'd2;
        for (int m = 0; m < 256; m++) begin
            logic [7:0] sel;
            sel = 8'(m * 37 + 11);
            for (int i = 0; i < N; i++) begin
                d[i*AW +: AW] = sel[i] ? 3'd2 : (3'd2 ^ AW'(1 + (i % 7)));
                t[i*TW +: TW] = TW'(m ^ (i * 17));
            end
            // R8: invalid cells aimed at this outlet (bits of sel outside m)
            step(m[N-1:0], d, t);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule